// File: doc/BRIEF.md
# Machine State Register Write Unit

A purely combinational datapath that computes the next machine state register value for the move-to instructions and returns the current value for the move-from instruction. Two move-to forms exist. The narrow form touches only the lower word of the register. The wide form also updates most of the upper word. A light-update selector cuts either form down to the two interrupt-related bits.

Bits are numbered big-endian: bit k is vector index 63-k. Within the fields each form updates, three enable bits are forced on whenever the incoming problem-state bit is set. The transaction-state field also has a guard that can block its update. The surrounding pipeline registers the result and uses the write strobe to commit it. Exception and privilege checks belong to other stages.

Top module: `msr_write_unit`

## Requirements
- R1: `op_i` encodes 0 = no operation, 1 = narrow move-to, 2 = wide move-to, 3 = move-from. For move-from, `rd_data_o` equals `msr_i`. For every other code, `rd_data_o` is zero.
- R2: `wr_valid_o` is 1 exactly for codes 1 and 2. When it is 0, `msr_o` equals `msr_i`.
- R3: For a move-to with `light_i`=0, new bits 48, 58 and 59 each equal the source bit of the same number OR source bit 49.
- R4: A narrow move-to with `light_i`=0 copies source bits 32–47, 49–50, 52–57 and 60–62.
- R5: A narrow move-to leaves bits 0–31 at their old values.
- R6: A wide move-to with `light_i`=0 also copies source bits 0–2 and 4–28. Bit 3 keeps its old value in every case.
- R7: For a wide move-to with `light_i`=0, bits 29–31 take the source value. The exception is when old bits 29–31 are 010 and source bits 29–31 are 000; then the old value is kept.
- R8: For a move-to with `light_i`=1, only bits 48 and 62 are copied from the source. All other bits keep their old values, and no problem-state forcing applies.
- R9: Bits 51 and 63 are never changed by any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msr_i | input | 64 | Current register value |
| src_i | input | 64 | Source operand for move-to |
| op_i | input | 2 | Operation code (see R1) |
| light_i | input | 1 | Light-update selector |
| msr_o | output | 64 | Next register value |
| wr_valid_o | output | 1 | Commit strobe for `msr_o` |
| rd_data_o | output | 64 | Move-from result |

## Verification
The hardest case to reach from the ports is the transaction-state guard. It needs one exact pair of old and source patterns, and it only matters in the wide form with light update off. Random operands almost never produce that pair. The stimulus therefore sets old 010 with source 000 directly, and then tries the neighbouring pairs on both sides. The problem-state override is handled the same way: the source is driven with bit 49 set while bits 48, 58 and 59 are clear.

// File: rtl/msr_wr_pkg.sv
package msr_wr_pkg;
  localparam int unsigned MSR_W = 64;
  localparam int unsigned OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 2'd0,
    OP_MT32 = 2'd1,
    OP_MT64 = 2'd2,
    OP_MF   = 2'd3
  } msr_op_e;

  // big-endian bit number -> vector index
  function automatic int unsigned be(input int unsigned k);
    return MSR_W - 1 - k;
  endfunction

  function automatic logic [MSR_W-1:0] be_span(input int unsigned lo, input int unsigned hi);
    logic [MSR_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < MSR_W; k++)
      if (k >= lo && k <= hi) m[MSR_W-1-k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/msr_copy_mask.sv
module msr_copy_mask
  import msr_wr_pkg::*;
(
  input  logic             wr_i,
  input  logic             full_i,
  input  logic             light_i,
  input  logic             ts_upd_i,
  output logic [MSR_W-1:0] mask_o
);
  localparam logic [MSR_W-1:0] M_BASE  = be_span(32, 47) | be_span(49, 50) |
                                         be_span(52, 57) | be_span(60, 62);
  localparam logic [MSR_W-1:0] M_PR    = be_span(48, 48) | be_span(58, 59);
  localparam logic [MSR_W-1:0] M_EXT   = be_span(0, 2) | be_span(4, 28);
  localparam logic [MSR_W-1:0] M_TS    = be_span(29, 31);
  localparam logic [MSR_W-1:0] M_LIGHT = be_span(48, 48) | be_span(62, 62);

  always_comb begin
    if (!wr_i)        mask_o = '0;
    else if (light_i) mask_o = M_LIGHT;
    else              mask_o = M_BASE | M_PR | (full_i ? M_EXT : '0) | (ts_upd_i ? M_TS : '0);
  end
endmodule

// File: rtl/msr_ts_guard.sv
module msr_ts_guard (
  input  logic [2:0] old_ts_i,
  input  logic [2:0] src_ts_i,
  input  logic       full_i,
  input  logic       light_i,
  output logic       upd_o
);
  logic blocked;
  assign blocked = (old_ts_i == 3'b010) && (src_ts_i == 3'b000);
  assign upd_o   = full_i && !light_i && !blocked;

  always_comb begin
    p_guard_block_r7: assert (!(old_ts_i == 3'b010 && src_ts_i == 3'b000) || !upd_o)
      else $error("ts guard let a blocked update through");
  end
endmodule

// File: rtl/msr_pr_force.sv
module msr_pr_force
  import msr_wr_pkg::*;
(
  input  logic             en_i,
  input  logic [MSR_W-1:0] src_i,
  output logic [MSR_W-1:0] src_o
);
  localparam int unsigned N_FORCED = 3;
  localparam int unsigned FORCED_BITS [N_FORCED] = '{48, 58, 59};
  localparam int unsigned PR_IDX = MSR_W - 1 - 49;

  logic pr;
  assign pr = en_i & src_i[PR_IDX];

  for (genvar i = 0; i < MSR_W; i++) begin : g_bit
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < N_FORCED; j++)
        if (MSR_W - 1 - FORCED_BITS[j] == i) hit = 1'b1;
    end
    assign src_o[i] = src_i[i] | (hit & pr);
  end
endmodule

// File: rtl/msr_write_unit.sv
module msr_write_unit
  import msr_wr_pkg::*;
(
  input  logic [63:0] msr_i,
  input  logic [63:0] src_i,
  input  logic [1:0]  op_i,
  input  logic        light_i,
  output logic [63:0] msr_o,
  output logic        wr_valid_o,
  output logic [63:0] rd_data_o
);
  localparam int unsigned I_TS_HI = MSR_W - 1 - 29;
  localparam int unsigned I_TS_LO = MSR_W - 1 - 31;
  localparam int unsigned I_B3    = MSR_W - 1 - 3;
  localparam int unsigned I_B48   = MSR_W - 1 - 48;
  localparam int unsigned I_B49   = MSR_W - 1 - 49;
  localparam int unsigned I_B51   = MSR_W - 1 - 51;
  localparam int unsigned I_B58   = MSR_W - 1 - 58;
  localparam int unsigned I_B59   = MSR_W - 1 - 59;
  localparam int unsigned I_B62   = MSR_W - 1 - 62;
  localparam int unsigned I_B63   = MSR_W - 1 - 63;

  logic             is_mt32, is_mt64, is_mf, wr;
  logic             ts_upd;
  logic [MSR_W-1:0] copy_mask, src_eff;

  assign is_mt32    = (op_i == OP_MT32);
  assign is_mt64    = (op_i == OP_MT64);
  assign is_mf      = (op_i == OP_MF);
  assign wr         = is_mt32 | is_mt64;
  assign wr_valid_o = wr;
  assign rd_data_o  = is_mf ? msr_i : '0;

  msr_ts_guard i_ts_guard (
    .old_ts_i (msr_i[I_TS_HI:I_TS_LO]),
    .src_ts_i (src_i[I_TS_HI:I_TS_LO]),
    .full_i   (is_mt64),
    .light_i  (light_i),
    .upd_o    (ts_upd)
  );

  msr_copy_mask i_copy_mask (
    .wr_i     (wr),
    .full_i   (is_mt64),
    .light_i  (light_i),
    .ts_upd_i (ts_upd),
    .mask_o   (copy_mask)
  );

  msr_pr_force i_pr_force (
    .en_i  (wr & ~light_i),
    .src_i (src_i),
    .src_o (src_eff)
  );

  for (genvar i = 0; i < MSR_W; i++) begin : g_merge
    assign msr_o[i] = copy_mask[i] ? src_eff[i] : msr_i[i];
  end

  always_comb begin
    p_hold_r2: assert (wr_valid_o || msr_o == msr_i)
      else $error("msr changed without write strobe");
    p_fixed_bits_r9: assert (msr_o[I_B51] == msr_i[I_B51] && msr_o[I_B63] == msr_i[I_B63])
      else $error("bit 51 or 63 changed");
    p_keep_bit3_r6: assert (msr_o[I_B3] == msr_i[I_B3])
      else $error("bit 3 changed");
    p_upper_keep_r5: assert (!is_mt32 || msr_o[MSR_W-1:MSR_W-32] == msr_i[MSR_W-1:MSR_W-32])
      else $error("narrow form touched bits 0-31");
    p_pr_force_r3: assert (!(wr && !light_i && src_i[I_B49]) ||
                           (msr_o[I_B48] && msr_o[I_B58] && msr_o[I_B59]))
      else $error("problem state did not force enables");
    p_light_only_r8: assert (!(wr && light_i) ||
                             (((msr_o ^ msr_i) & ~((64'd1 << I_B48) | (64'd1 << I_B62))) == '0))
      else $error("light update touched other bits");
    p_rd_idle_r1: assert (is_mf || rd_data_o == '0)
      else $error("read port active outside move-from");
  end
endmodule

// File: tb/test_msr_write_unit.sv
module test_msr_write_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] msr_i, src_i, msr_o, rd_data_o;
  logic [1:0]  op_i;
  logic        light_i, wr_valid_o;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msr_write_unit i_msr_write_unit (
    .msr_i(msr_i), .src_i(src_i), .op_i(op_i), .light_i(light_i),
    .msr_o(msr_o), .wr_valid_o(wr_valid_o), .rd_data_o(rd_data_o)
  );

  function automatic logic bb(input logic [63:0] v, input int k);
    return v[63-k];
  endfunction

  function automatic logic [63:0] ref_msr(input logic [63:0] old, input logic [63:0] s,
                                          input logic [1:0] op, input logic lt);
    logic [63:0] r;
    logic pr;
    r  = old;
    pr = bb(s, 49);
    if (op == 2'd1 || op == 2'd2) begin
      if (lt) begin
        r[63-48] = bb(s, 48);
        r[63-62] = bb(s, 62);
      end else begin
        for (int k = 0; k < 64; k++) begin
          if ((k >= 32 && k <= 47) || k == 49 || k == 50 ||
              (k >= 52 && k <= 57) || (k >= 60 && k <= 62)) r[63-k] = bb(s, k);
          if (k == 48 || k == 58 || k == 59) r[63-k] = bb(s, k) | pr;
          if (op == 2'd2 && (k <= 2 || (k >= 4 && k <= 28))) r[63-k] = bb(s, k);
        end
        if (op == 2'd2 && !(old[34:32] == 3'b010 && s[34:32] == 3'b000))
          r[34:32] = s[34:32];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at posedge, compare at the following negedge
  task automatic apply(input string tag, input logic [63:0] m, input logic [63:0] s,
                       input logic [1:0] op, input logic lt);
    @(posedge clk);
    msr_i = m; src_i = s; op_i = op; light_i = lt;
    @(negedge clk);
    chk({tag, " msr"}, msr_o, ref_msr(m, s, op, lt));
    chk({tag, " wr"}, {63'd0, wr_valid_o}, {63'd0, (op == 2'd1 || op == 2'd2)});
    chk({tag, " rd"}, rd_data_o, (op == 2'd3) ? m : 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    msr_i = '0; src_i = '0; op_i = 2'd0; light_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset wr", {63'd0, wr_valid_o}, 64'd0);
    chk("R1 reset rd", rd_data_o, 64'd0);
    chk("R2 reset msr", msr_o, 64'd0);

    apply("R2 idle", 64'hdead_beef_0123_4567, '1, 2'd0, 1'b0);
    apply("R1 mfmsr", 64'h0123_4567_89ab_cdef, 64'hffff_0000_ffff_0000, 2'd3, 1'b0);

    apply("R4 narrow ones", '0, '1, 2'd1, 1'b0);
    chk("R5 narrow upper", {32'd0, msr_o[63:32]}, 64'd0);
    chk("R9 narrow 51/63", {62'd0, msr_o[63-51], msr_o[0]}, 64'd0);
    apply("R5 narrow zeros", '1, '0, 2'd1, 1'b0);
    chk("R5 narrow keep", {32'd0, msr_o[63:32]}, {32'd0, 32'hffff_ffff});

    apply("R3 pr force", '0, 64'd1 << (63-49), 2'd1, 1'b0);
    chk("R3 bits48/58/59", {61'd0, msr_o[63-48], msr_o[63-58], msr_o[63-59]}, 64'd7);
    apply("R3 wide pr", '0, 64'd1 << (63-49), 2'd2, 1'b0);

    apply("R6 wide ones", '0, '1, 2'd2, 1'b0);
    chk("R6 bit3 kept", {63'd0, msr_o[63-3]}, 64'd0);
    chk("R9 wide 51/63", {62'd0, msr_o[63-51], msr_o[0]}, 64'd0);
    apply("R6 wide bit3 one", 64'd1 << (63-3), '0, 2'd2, 1'b0);

    apply("R7 ts blocked", 64'h0000_0002_0000_0000, 64'h0, 2'd2, 1'b0);
    chk("R7 ts kept", {61'd0, msr_o[34:32]}, 64'd2);
    apply("R7 ts src001", 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 2'd2, 1'b0);
    chk("R7 ts written", {61'd0, msr_o[34:32]}, 64'd1);
    apply("R7 ts old011", 64'h0000_0003_0000_0000, 64'h0, 2'd2, 1'b0);
    chk("R7 ts cleared", {61'd0, msr_o[34:32]}, 64'd0);
    apply("R7 ts narrow", 64'h0000_0003_0000_0000, 64'h0, 2'd1, 1'b0);
    apply("R7 ts light", 64'h0000_0005_0000_0000, 64'h0, 2'd2, 1'b1);

    apply("R8 light narrow", '0, '1, 2'd1, 1'b1);
    chk("R8 only 48/62", msr_o, (64'd1 << (63-48)) | (64'd1 << (63-62)));
    apply("R8 light pr", '0, 64'd1 << (63-49), 2'd2, 1'b1);
    chk("R8 no forcing", msr_o, 64'd0);
    apply("R8 light clear", '1, '0, 2'd2, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] m, s;
      m = {$urandom, $urandom};
      s = {$urandom, $urandom};
      if (i % 7 == 0) begin m[34:32] = 3'b010; s[34:32] = 3'b000; end
      apply("R9 random", m, s, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      chk("R9 random fixed", {62'd0, msr_o[63-51], msr_o[0]}, {62'd0, m[63-51], m[0]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule